// File: doc/BRIEF.md
# Bus-Matching Endian Width Converter

This block is the storage and data path of a single-clock FIFO whose write side and read side are each, independently, 18 bits or 9 bits wide. Three strap inputs are captured while the synchronous reset is held: one selects the write width, one selects the read width, and one selects the byte order. Every word is stored internally as 9-bit lanes in a byte-addressed buffer, so any mix of widths shares one pointer scheme.

When a long word is read back as two short ones, the byte-order strap decides whether its upper or lower half comes out first. When two short words are written and read back as one long word, the same strap decides which of the two fills the upper half. Empty and full are counted in lanes and follow the width of the port they guard.

Top module: `bus_match_fifo`

## Requirements
- R1: The straps are sampled on every clock edge while rst is high and held after; in_narrow=0/out_narrow=0 gives 18-bit write and 18-bit read, 0/1 gives 18-bit write and 9-bit read, 1/0 gives 9-bit write and 18-bit read, 1/1 gives 9-bit write and 9-bit read. Strap changes while rst is low have no effect.
- R2: On the edge after rst is high, empty is 1, full is 0 and rd_data is all zero.
- R3: With 18-bit writes, 9-bit reads and big_end=1, each long word is read as wr_data[17:9] first and wr_data[8:0] second.
- R4: With 18-bit writes, 9-bit reads and big_end=0, each long word is read as wr_data[8:0] first and wr_data[17:9] second.
- R5: With 9-bit writes (data on wr_data[8:0]) and 18-bit reads, two successive writes form one word; the first lands in rd_data[17:9] when big_end=1 and in rd_data[8:0] when big_end=0.
- R6: When read and write widths match, words come out unchanged and in write order, for either byte order.
- R7: In 9-bit read mode the lane appears on rd_data[8:0] and rd_data[17:9] is zero.
- R8: rd_data changes on the clock edge that accepts a read and holds its value otherwise.
- R9: The buffer holds DEPTH lanes; empty is 1 while fewer lanes are stored than one read takes, full is 1 while fewer lanes are free than one write takes.
- R10: A read while empty or a write while full is ignored: stored data, order and rd_data are unchanged.
- R11: A read and a write in the same cycle are both accepted when each is allowed by the flags of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps sampled while high |
| strap_in_narrow | input | 1 | 1 selects 9-bit writes |
| strap_out_narrow | input | 1 | 1 selects 9-bit reads |
| strap_big_end | input | 1 | 1 selects upper half first |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write data (9-bit mode uses bits 8:0) |
| rd_en | input | 1 | Read request |
| rd_data | output | 18 | Read data, registered |
| empty | output | 1 | No complete read word stored |
| full | output | 1 | No room for a complete write word |

## Verification
Every cycle, the assertions check the reset state of the flags and output, that the captured configuration never moves outside reset, that the lane count stays within capacity, that empty and full never coincide, that rejected reads leave rd_data still and rejected writes leave the count alone, and that narrow reads keep the upper lanes zero. Lane ordering across widths and byte orders, the packing of two narrow writes into one wide word and the exact moments empty and full change can only be shown by the bench's scenarios, which run every strap combination against a lane-queue model.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int LANE_W = 9;
  localparam int WORD_W = 2 * LANE_W;

  typedef logic [LANE_W-1:0] lane_t;

  typedef struct packed {
    logic in_narrow;
    logic out_narrow;
    logic big_end;
  } bm_cfg_t;

  // Lane of a long word that enters the stream first
  function automatic lane_t lead_lane(input logic [WORD_W-1:0] w, input logic big);
    return big ? w[WORD_W-1:LANE_W] : w[LANE_W-1:0];
  endfunction

  function automatic lane_t trail_lane(input logic [WORD_W-1:0] w, input logic big);
    return big ? w[LANE_W-1:0] : w[WORD_W-1:LANE_W];
  endfunction

  // Rebuild a long word from two lanes in stream order
  function automatic logic [WORD_W-1:0] join_lanes(input lane_t first, input lane_t second,
                                                   input logic big);
    return big ? {first, second} : {second, first};
  endfunction
endpackage

// File: rtl/bm_strap_latch.sv
module bm_strap_latch
  import bm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    in_narrow,
  input  logic    out_narrow,
  input  logic    big_end,
  output bm_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.in_narrow  <= in_narrow;
      cfg.out_narrow <= out_narrow;
      cfg.big_end    <= big_end;
    end
  end
endmodule

// File: rtl/bm_lane_bank.sv
module bm_lane_bank #(
  parameter int W    = 9,
  parameter int ROWS = 8,
  localparam int RA  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RA-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [RA-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bus_match_fifo.sv
module bus_match_fifo
  import bm_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_in_narrow,
  input  logic              strap_out_narrow,
  input  logic              strap_big_end,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              empty,
  output logic              full
);
  localparam int AW   = $clog2(DEPTH);
  localparam int ROWS = DEPTH / 2;
  localparam int RA   = AW - 1;

  bm_cfg_t cfg;
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt, cnt_nxt, wstep, rstep;
  logic          wr_ok, rd_ok;
  logic          first_sel;
  lane_t         bank_q [2];
  lane_t         s_lead, s_trail;
  logic [AW-1:0] wp_inc, rp_inc;

  bm_strap_latch u_straps (
    .clk(clk), .rst(rst),
    .in_narrow(strap_in_narrow), .out_narrow(strap_out_narrow), .big_end(strap_big_end),
    .cfg(cfg)
  );

  assign wstep = cfg.in_narrow  ? (AW+1)'(1) : (AW+1)'(2);
  assign rstep = cfg.out_narrow ? (AW+1)'(1) : (AW+1)'(2);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;
  assign cnt_nxt = cnt + (wr_ok ? wstep : '0) - (rd_ok ? rstep : '0);

  // Stream order of the incoming lanes
  assign s_lead  = cfg.in_narrow ? wr_data[LANE_W-1:0] : lead_lane(wr_data, cfg.big_end);
  assign s_trail = trail_lane(wr_data, cfg.big_end);
  assign wp_inc  = wp + 1'b1;
  assign rp_inc  = rp + 1'b1;

  // Lane address a lives in bank a[0], row a>>1
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic          b_we;
    logic [RA-1:0] b_waddr, b_raddr;
    lane_t         b_wdata;

    assign b_we    = wr_ok && (!cfg.in_narrow || (wp[0] == 1'(b)));
    assign b_wdata = (wp[0] == 1'(b)) ? s_lead : s_trail;
    assign b_waddr = (b == 0) ? wp_inc[AW-1:1] : wp[AW-1:1];
    assign b_raddr = (b == 0) ? rp_inc[AW-1:1] : rp[AW-1:1];

    bm_lane_bank #(.W(LANE_W), .ROWS(ROWS)) u_bank (
      .clk(clk), .rst(rst),
      .we(b_we), .waddr(b_waddr), .wdata(b_wdata),
      .re(rd_ok), .raddr(b_raddr), .rdata(bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      empty     <= 1'b1;
      full      <= 1'b0;
      first_sel <= 1'b0;
    end else begin
      if (wr_ok) wp <= wp + wstep[AW-1:0];
      if (rd_ok) begin
        rp        <= rp + rstep[AW-1:0];
        first_sel <= rp[0];
      end
      cnt   <= cnt_nxt;
      empty <= cnt_nxt < rstep;
      full  <= ((AW+1)'(DEPTH) - cnt_nxt) < wstep;
    end
  end

  lane_t out_first, out_second;
  assign out_first  = first_sel ? bank_q[1] : bank_q[0];
  assign out_second = first_sel ? bank_q[0] : bank_q[1];

  always_comb begin
    if (cfg.out_narrow) rd_data = {{LANE_W{1'b0}}, out_first};
    else                rd_data = join_lanes(out_first, out_second, cfg.big_end);
  end
endmodule

// File: rtl/bm_checker.sv
module bm_checker
  import bm_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input bm_cfg_t           cfg,
  input logic [AW:0]       cnt,
  input logic              wr_en,
  input logic              rd_en,
  input logic [WORD_W-1:0] rd_data,
  input logic              empty,
  input logic              full
);
  a_r2_reset_state: assert property (@(posedge clk)
    rst |=> (empty && !full && rd_data == '0));

  a_r1_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(cfg));

  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH));

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  a_r10_empty_read_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> $stable(rd_data));

  a_r10_full_write_drop: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (full && $stable(cnt)));

  a_r7_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    cfg.out_narrow |-> (rd_data[WORD_W-1:LANE_W] == '0));
endmodule

bind bus_match_fifo bm_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cfg(cfg), .cnt(cnt),
  .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .empty(empty), .full(full)
);

// File: tb/sim_bus_match_fifo.sv
module sim_bus_match_fifo;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_in = 1'b0, s_out = 1'b0, s_big = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [17:0] wr_data = '0;
  logic [17:0] rd_data;
  logic        empty, full;

  always #2.5 clk = ~clk;

  bus_match_fifo #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst),
    .strap_in_narrow(s_in), .strap_out_narrow(s_out), .strap_big_end(s_big),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .empty(empty), .full(full)
  );

  int vectors = 0;
  int errors  = 0;

  // Lane-queue model
  logic [8:0]  mq [DEPTH];
  int          m_head, m_cnt;
  logic        m_in, m_out, m_big;
  logic [17:0] exp_rd;
  string       pend_tag;

  function automatic string mode_tag(input logic i, input logic o, input logic b);
    if (i == o) return "R6";
    if (!i)     return b ? "R3" : "R4";
    return "R5";
  endfunction

  function automatic int rbytes(input logic o); return o ? 1 : 2; endfunction
  function automatic int wbytes(input logic i); return i ? 1 : 2; endfunction

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_lane(input logic [8:0] v);
    mq[(m_head + m_cnt) % DEPTH] = v;
    m_cnt++;
  endtask

  function automatic logic [8:0] pop_lane();
    logic [8:0] v = mq[m_head];
    m_head = (m_head + 1) % DEPTH;
    m_cnt--;
    return v;
  endfunction

  task automatic do_reset(input logic i, input logic o, input logic b);
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    s_in = i; s_out = o; s_big = b;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_in = i; m_out = o; m_big = b;
    m_head = 0; m_cnt = 0; exp_rd = '0;
    pend_tag = "R2";
  endtask

  // One cycle: check state at the negedge, drive, update the model for the edge
  task automatic step(input logic we, input logic [17:0] wd, input logic re);
    logic wacc, racc;
    logic [8:0] f, s;
    @(negedge clk);
    check({pend_tag, " rd_data"}, rd_data, exp_rd);
    check("R9 empty", {17'b0, empty}, {17'b0, (m_cnt < rbytes(m_out))});
    check("R9 full",  {17'b0, full},  {17'b0, ((DEPTH - m_cnt) < wbytes(m_in))});
    // R1: straps wander outside reset and must not matter
    s_in = 1'($urandom); s_out = 1'($urandom); s_big = 1'($urandom);
    wr_en = we; wr_data = wd; rd_en = re;
    racc = re && (m_cnt >= rbytes(m_out));
    wacc = we && ((DEPTH - m_cnt) >= wbytes(m_in));
    if (racc) begin
      f = pop_lane();
      if (m_out) exp_rd = {9'b0, f};                 // R7
      else begin
        s = pop_lane();
        exp_rd = m_big ? {f, s} : {s, f};
      end
    end
    if (wacc) begin
      if (m_in) push_lane(wd[8:0]);
      else begin
        push_lane(m_big ? wd[17:9] : wd[8:0]);
        push_lane(m_big ? wd[8:0] : wd[17:9]);
      end
    end
    if (re && !racc)       pend_tag = "R10";
    else if (racc && wacc) pend_tag = "R11";
    else if (racc)         pend_tag = mode_tag(m_in, m_out, m_big);
    else                   pend_tag = "R8";
    if (we && !wacc) pend_tag = "R10";
  endtask

  function automatic logic [17:0] rnd_word(input logic narrow);
    logic [17:0] w = 18'($urandom);
    return narrow ? {9'b0, w[8:0]} : w;
  endfunction

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int mode = 0; mode < 8; mode++) begin
      logic mi = mode[2], mo = mode[1], mb = mode[0];
      do_reset(mi, mo, mb);
      @(negedge clk);
      // R2: reset state
      check("R2 empty", {17'b0, empty}, 18'd1);
      check("R2 full", {17'b0, full}, 18'd0);
      check("R2 rd_data", rd_data, 18'd0);
      // R10: read while empty
      step(1'b0, '0, 1'b1);
      // Directed ordering: R3/R4 (wide in, narrow out), R5 (narrow in, wide out), R6
      step(1'b1, mi ? 18'h0_00A5 : {9'h1C3, 9'h04E}, 1'b0);
      step(1'b1, mi ? 18'h0_013C : {9'h0F0, 9'h10F}, 1'b0);
      for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b1);
      // Fill past capacity (R9, R10), then drain
      for (int k = 0; k < DEPTH + 3; k++) step(1'b1, rnd_word(mi), 1'b0);
      for (int k = 0; k < DEPTH + 3; k++) step(1'b0, '0, 1'b1);
      // Random phases biased toward filling and draining; R11 when both accepted
      for (int k = 0; k < 400; k++) begin
        int pw = ((k / 40) % 2 == 0) ? 75 : 30;
        int pr = ((k / 40) % 2 == 0) ? 35 : 80;
        step(($urandom % 100) < pw, rnd_word(mi), ($urandom % 100) < pr);
      end
      step(1'b0, '0, 1'b0);
    end
    @(negedge clk);
    check({pend_tag, " rd_data"}, rd_data, exp_rd);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule